// File: doc/BRIEF.md
# Rename Stage Status Controller

This block decides, once per clock and independently for each hardware thread, what the register rename stage of an out-of-order core does next: run normally, hold because something downstream is full or has asked it to stop, drain its held instructions after a hold, recover from a pipeline flush, or wait for the machine to go quiet before a serializing instruction proceeds. The instruction buffers are not part of the block. It sees only their summary signals (whether the skid buffer is empty) and it signals back which action is due.

For every thread it keeps three credit counters, for reorder buffer, issue queue and load/store queue slots, which are overwritten whenever the downstream stages report a fresh value. It also keeps a count of renamed instructions that have not yet been dispatched. A slot estimate is a reported credit minus the instructions still in flight net of this cycle's dispatches. Two sticky hold flags, one owned by the execute stage and one by the commit stage, are raised and lowered by pulses. A held serializing instruction is released with a one-cycle re-inject pulse that also says which queue it goes back into.

Top module: `rename_status_ctrl`

## Requirements
- R1: Reset puts every thread in state code 0 (run; the codes are run 0, blocked 1, unblocking 2, squashing 3, serialize-wait 4) with both hold flags clear, no in-flight instructions, the reorder buffer marked empty and the credits at their parameter defaults. The block-upstream, re-inject and error outputs are low.
- R2: A flush request takes the thread to squashing on the next cycle, ahead of every other condition, a simultaneous hold included.
- R3: While no flush request is present, a reorder-buffer-still-squashing indication keeps the thread in squashing, even when a hold condition is present.
- R4: A block pulse from the execute or commit stage sets that stage's sticky flag. The flag holds the thread in blocked until the matching unblock pulse. A pulse takes effect in the cycle it arrives. A block and an unblock for the same stage in the same cycle leave the flag clear.
- R5: An unblock pulse for a stage whose flag is clear, with no block for that stage in the same cycle, raises the error output for exactly one cycle. Once the hold ends, blocked moves to unblocking. Unblocking moves to run in a cycle where the skid buffer is empty and stays in unblocking otherwise.
- R6: Reorder buffer and issue queue free slots are each credit minus (in-flight minus dispatched this cycle). Load/store free slots use the load/store-dispatched count instead. Any estimate at or below zero blocks the thread, and an estimate of one does not.
- R7: A credit value changes only in a cycle where its valid flag is set. The reorder-buffer-empty flag is taken only together with the reorder buffer credit. A credit with its valid flag set is used in the same cycle's decision.
- R8: A rename map free count at or below zero blocks the thread.
- R9: On leaving squashing, the thread goes to serialize-wait if the flush arrived while it was in serialize-wait. It goes to unblocking if the flush arrived while it was blocked or unblocking. Otherwise it goes to run.
- R10: In run, a serialize request moves the thread to serialize-wait. The thread stays there, and never falls to blocked, while the reorder buffer is not empty or any instruction is in flight.
- R11: Leaving serialize-wait goes to unblocking with a one-cycle re-inject pulse. The queue-select output is 1 (front of skid buffer) when the skid buffer is non-empty, and 0 (front of the normal queue) otherwise.
- R12: The block-upstream output is high exactly while the thread is blocked or unblocking.
- R13: Threads are independent: inputs to one thread never change another thread's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | NTHR | Flush request from commit, per thread |
| rob_sq_i | input | NTHR | Reorder buffer still squashing |
| exe_blk_i | input | NTHR | Execute stage block pulse |
| exe_unblk_i | input | NTHR | Execute stage unblock pulse |
| cmt_blk_i | input | NTHR | Commit stage block pulse |
| cmt_unblk_i | input | NTHR | Commit stage unblock pulse |
| rob_vld_i | input | NTHR | Reorder buffer credit and empty flag valid |
| rob_cr_i | input | NTHR*CW | Reorder buffer credit, signed |
| rob_empty_i | input | NTHR | Reorder buffer empty |
| iq_vld_i | input | NTHR | Issue queue credit valid |
| iq_cr_i | input | NTHR*CW | Issue queue credit, signed |
| lsq_vld_i | input | NTHR | Load/store queue credit valid |
| lsq_cr_i | input | NTHR*CW | Load/store queue credit, signed |
| map_free_i | input | NTHR*CW | Rename map free entries, signed |
| renamed_i | input | NTHR*CW | Instructions renamed this cycle |
| disp_i | input | NTHR*CW | Instructions dispatched this cycle |
| lsq_disp_i | input | NTHR*CW | Instructions dispatched to load/store queue this cycle |
| ser_req_i | input | NTHR | Serializing instruction reached rename |
| skid_empty_i | input | NTHR | Skid buffer empty |
| state_o | output | NTHR*3 | Current state code |
| block_up_o | output | NTHR | Block request to decode |
| reinj_o | output | NTHR | Re-inject held serializing instruction |
| reinj_skid_o | output | NTHR | Re-inject target: 1 skid buffer, 0 normal queue |
| unblk_err_o | output | NTHR | Unblock received with no block pending |

## Verification
Every decision in a cycle is registered once. A state change, the re-inject pulse and the error pulse caused by inputs present at one rising edge are visible right after that edge and last until the next one. The bench changes inputs at the falling edge, lets exactly one rising edge pass and samples at the following falling edge. Single-cycle pulses are cleared at that point, so each check sees the result of one cycle's inputs. Multi-cycle effects, such as the in-flight count feeding the next cycle's slot estimate or serialize-wait holding on the stored in-flight count, are checked one edge at a time, with the expected code worked out from the arithmetic in R6 and the order in R9.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    RS_RUN     = 3'd0,
    RS_BLOCKED = 3'd1,
    RS_UNBLK   = 3'd2,
    RS_SQUASH  = 3'd3,
    RS_SERIAL  = 3'd4
  } rs_state_e;

  function automatic logic holds_upstream(input rs_state_e s);
    return (s == RS_BLOCKED) || (s == RS_UNBLK);
  endfunction

endpackage

// File: rtl/rsc_credit_track.sv
module rsc_credit_track #(
  parameter int CW       = 8,
  parameter int ROB_INIT = 16,
  parameter int IQ_INIT  = 16,
  parameter int LSQ_INIT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rob_vld,
  input  logic signed [CW-1:0] rob_cr,
  input  logic                 rob_empty_in,
  input  logic                 iq_vld,
  input  logic signed [CW-1:0] iq_cr,
  input  logic                 lsq_vld,
  input  logic signed [CW-1:0] lsq_cr,
  input  logic signed [CW-1:0] map_free,
  input  logic signed [CW-1:0] renamed,
  input  logic signed [CW-1:0] disp,
  input  logic signed [CW-1:0] lsq_disp,
  output logic                 res_stall,
  output logic                 rob_empty_eff,
  output logic                 inflight_nz
);

  localparam logic signed [CW-1:0] ROB_RST = CW'(ROB_INIT);
  localparam logic signed [CW-1:0] IQ_RST  = CW'(IQ_INIT);
  localparam logic signed [CW-1:0] LSQ_RST = CW'(LSQ_INIT);

  logic signed [CW-1:0] rob_q, iq_q, lsq_q, infl_q;
  logic                 rob_empty_q;
  logic signed [CW-1:0] rob_eff, iq_eff, lsq_eff;
  logic signed [CW-1:0] rob_free, iq_free, lsq_free;
  logic                 rob_full, iq_full, lsq_full, map_full;

  // slot estimate: reported credit less instructions not yet gone downstream
  function automatic logic signed [CW-1:0] free_est(
    input logic signed [CW-1:0] credit,
    input logic signed [CW-1:0] in_flight,
    input logic signed [CW-1:0] gone
  );
    return credit - (in_flight - gone);
  endfunction

  function automatic logic at_or_below_zero(input logic signed [CW-1:0] v);
    return v <= 0;
  endfunction

  always_comb begin
    rob_eff       = rob_vld ? rob_cr : rob_q;
    iq_eff        = iq_vld  ? iq_cr  : iq_q;
    lsq_eff       = lsq_vld ? lsq_cr : lsq_q;
    rob_empty_eff = rob_vld ? rob_empty_in : rob_empty_q;
    rob_free      = free_est(rob_eff, infl_q, disp);
    iq_free       = free_est(iq_eff,  infl_q, disp);
    lsq_free      = free_est(lsq_eff, infl_q, lsq_disp);
    rob_full      = at_or_below_zero(rob_free);
    iq_full       = at_or_below_zero(iq_free);
    lsq_full      = at_or_below_zero(lsq_free);
    map_full      = at_or_below_zero(map_free);
    res_stall     = rob_full | iq_full | lsq_full | map_full;
    inflight_nz   = (infl_q != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rob_q       <= ROB_RST;
      iq_q        <= IQ_RST;
      lsq_q       <= LSQ_RST;
      rob_empty_q <= 1'b1;
      infl_q      <= '0;
    end else begin
      if (rob_vld) begin
        rob_q       <= rob_cr;
        rob_empty_q <= rob_empty_in;
      end
      if (iq_vld)  iq_q  <= iq_cr;
      if (lsq_vld) lsq_q <= lsq_cr;
      infl_q <= infl_q + renamed - disp;
    end
  end

  assert_rob_credit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rob_vld |=> $stable(rob_q) && $stable(rob_empty_q));
  assert_iq_credit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !iq_vld |=> $stable(iq_q));
  assert_lsq_credit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lsq_vld |=> $stable(lsq_q));

endmodule

// File: rtl/rsc_stall_flags.sv
module rsc_stall_flags #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] blk,
  input  logic [NSRC-1:0] unblk,
  output logic            flag_stall,
  output logic            err
);

  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_eff;
  logic [NSRC-1:0] bad_unblk;
  logic            err_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    // a block then an unblock in one cycle: the unblock wins
    assign flag_eff[s]  = unblk[s] ? 1'b0 : (flag_q[s] | blk[s]);
    assign bad_unblk[s] = unblk[s] & ~flag_q[s] & ~blk[s];

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[s] <= 1'b0;
      else        flag_q[s] <= flag_eff[s];
    end

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[s] && !unblk[s] |=> flag_q[s]);
    assert_flag_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      unblk[s] |=> !flag_q[s]);
  end

  assign flag_stall = |flag_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |bad_unblk;
  end
  assign err = err_q;

endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm
  import rsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      rob_sq,
  input  logic      flag_stall,
  input  logic      res_stall,
  input  logic      rob_empty_eff,
  input  logic      inflight_nz,
  input  logic      ser_req,
  input  logic      skid_empty,
  output rs_state_e state,
  output logic      reinj,
  output logic      reinj_skid
);

  rs_state_e st_q, st_d;
  logic      res_unblk_q, res_unblk_d;
  logic      res_ser_q, res_ser_d;
  logic      reinj_q, reinj_d;
  logic      skid_q, skid_d;
  logic      ser_wait, stall_now;

  always_comb begin
    st_d        = st_q;
    res_unblk_d = res_unblk_q;
    res_ser_d   = res_ser_q;
    reinj_d     = 1'b0;
    skid_d      = 1'b0;
    ser_wait    = (st_q == RS_SERIAL) && (!rob_empty_eff || inflight_nz);
    stall_now   = flag_stall | res_stall | ser_wait;

    if (flush) begin
      st_d = RS_SQUASH;
      if (st_q == RS_BLOCKED || st_q == RS_UNBLK) res_unblk_d = 1'b1;
      if (st_q == RS_SERIAL)                      res_ser_d   = 1'b1;
    end else if (rob_sq) begin
      st_d = RS_SQUASH;
    end else if (stall_now) begin
      if (st_q == RS_SQUASH) begin
        res_unblk_d = 1'b0;
        res_ser_d   = 1'b0;
      end
      // a waiting serializing instruction keeps its own state
      if (st_q != RS_SERIAL) st_d = RS_BLOCKED;
    end else begin
      unique case (st_q)
        RS_BLOCKED: st_d = RS_UNBLK;
        RS_SQUASH: begin
          if (res_ser_q)        st_d = RS_SERIAL;
          else if (res_unblk_q) st_d = RS_UNBLK;
          else                  st_d = RS_RUN;
          res_unblk_d = 1'b0;
          res_ser_d   = 1'b0;
        end
        RS_SERIAL: begin
          st_d    = RS_UNBLK;
          reinj_d = 1'b1;
          skid_d  = ~skid_empty;
        end
        RS_UNBLK: if (skid_empty) st_d = RS_RUN;
        RS_RUN:   if (ser_req)    st_d = RS_SERIAL;
        default:  st_d = RS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= RS_RUN;
      res_unblk_q <= 1'b0;
      res_ser_q   <= 1'b0;
      reinj_q     <= 1'b0;
      skid_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      res_unblk_q <= res_unblk_d;
      res_ser_q   <= res_ser_d;
      reinj_q     <= reinj_d;
      skid_q      <= skid_d;
    end
  end

  assign state      = st_q;
  assign reinj      = reinj_q;
  assign reinj_skid = skid_q;

  assert_flush_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> st_q == RS_SQUASH);
  assert_rob_squashing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rob_sq |=> st_q == RS_SQUASH);
  assert_serial_never_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == RS_SERIAL && !flush && !rob_sq |=> st_q == RS_SERIAL || st_q == RS_UNBLK);
  assert_reinject_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reinj_q |-> st_q == RS_UNBLK && $past(st_q) == RS_SERIAL);
  assert_reinject_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reinj_q |=> !reinj_q);

endmodule

// File: rtl/rename_status_ctrl.sv
module rename_status_ctrl
  import rsc_pkg::*;
#(
  parameter int NTHR     = 2,
  parameter int CW       = 8,
  parameter int ROB_INIT = 16,
  parameter int IQ_INIT  = 16,
  parameter int LSQ_INIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTHR-1:0]   flush_i,
  input  logic [NTHR-1:0]   rob_sq_i,
  input  logic [NTHR-1:0]   exe_blk_i,
  input  logic [NTHR-1:0]   exe_unblk_i,
  input  logic [NTHR-1:0]   cmt_blk_i,
  input  logic [NTHR-1:0]   cmt_unblk_i,
  input  logic [NTHR-1:0]   rob_vld_i,
  input  logic [NTHR*CW-1:0] rob_cr_i,
  input  logic [NTHR-1:0]   rob_empty_i,
  input  logic [NTHR-1:0]   iq_vld_i,
  input  logic [NTHR*CW-1:0] iq_cr_i,
  input  logic [NTHR-1:0]   lsq_vld_i,
  input  logic [NTHR*CW-1:0] lsq_cr_i,
  input  logic [NTHR*CW-1:0] map_free_i,
  input  logic [NTHR*CW-1:0] renamed_i,
  input  logic [NTHR*CW-1:0] disp_i,
  input  logic [NTHR*CW-1:0] lsq_disp_i,
  input  logic [NTHR-1:0]   ser_req_i,
  input  logic [NTHR-1:0]   skid_empty_i,
  output logic [NTHR*3-1:0] state_o,
  output logic [NTHR-1:0]   block_up_o,
  output logic [NTHR-1:0]   reinj_o,
  output logic [NTHR-1:0]   reinj_skid_o,
  output logic [NTHR-1:0]   unblk_err_o
);

  localparam int NSRC = 2;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic      res_stall, rob_empty_eff, inflight_nz;
    logic      flag_stall;
    rs_state_e st;

    rsc_credit_track #(
      .CW(CW), .ROB_INIT(ROB_INIT), .IQ_INIT(IQ_INIT), .LSQ_INIT(LSQ_INIT)
    ) u_credit (
      .clk          (clk),
      .rst_n        (rst_n),
      .rob_vld      (rob_vld_i[t]),
      .rob_cr       (rob_cr_i[t*CW +: CW]),
      .rob_empty_in (rob_empty_i[t]),
      .iq_vld       (iq_vld_i[t]),
      .iq_cr        (iq_cr_i[t*CW +: CW]),
      .lsq_vld      (lsq_vld_i[t]),
      .lsq_cr       (lsq_cr_i[t*CW +: CW]),
      .map_free     (map_free_i[t*CW +: CW]),
      .renamed      (renamed_i[t*CW +: CW]),
      .disp         (disp_i[t*CW +: CW]),
      .lsq_disp     (lsq_disp_i[t*CW +: CW]),
      .res_stall    (res_stall),
      .rob_empty_eff(rob_empty_eff),
      .inflight_nz  (inflight_nz)
    );

    rsc_stall_flags #(.NSRC(NSRC)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk       ({cmt_blk_i[t], exe_blk_i[t]}),
      .unblk     ({cmt_unblk_i[t], exe_unblk_i[t]}),
      .flag_stall(flag_stall),
      .err       (unblk_err_o[t])
    );

    rsc_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush_i[t]),
      .rob_sq       (rob_sq_i[t]),
      .flag_stall   (flag_stall),
      .res_stall    (res_stall),
      .rob_empty_eff(rob_empty_eff),
      .inflight_nz  (inflight_nz),
      .ser_req      (ser_req_i[t]),
      .skid_empty   (skid_empty_i[t]),
      .state        (st),
      .reinj        (reinj_o[t]),
      .reinj_skid   (reinj_skid_o[t])
    );

    assign state_o[t*3 +: 3] = st;
    assign block_up_o[t]     = holds_upstream(st);

    assert_block_up_tracks_R12: assert property (@(posedge clk) disable iff (!rst_n)
      block_up_o[t] |-> st != RS_RUN && st != RS_SQUASH && st != RS_SERIAL);
  end

endmodule

// File: tb/rename_status_ctrl_bench.sv
module rename_status_ctrl_bench;

  localparam int NTHR = 2;
  localparam int CW   = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NTHR-1:0]   flush_i, rob_sq_i, exe_blk_i, exe_unblk_i, cmt_blk_i, cmt_unblk_i;
  logic [NTHR-1:0]   rob_vld_i, rob_empty_i, iq_vld_i, lsq_vld_i, ser_req_i, skid_empty_i;
  logic [NTHR*CW-1:0] rob_cr_i, iq_cr_i, lsq_cr_i, map_free_i, renamed_i, disp_i, lsq_disp_i;
  logic [NTHR*3-1:0] state_o;
  logic [NTHR-1:0]   block_up_o, reinj_o, reinj_skid_o, unblk_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rename_status_ctrl #(.NTHR(NTHR), .CW(CW)) u_rename_status_ctrl (
    .clk(clk), .rst_n(rst_n),
    .flush_i(flush_i), .rob_sq_i(rob_sq_i),
    .exe_blk_i(exe_blk_i), .exe_unblk_i(exe_unblk_i),
    .cmt_blk_i(cmt_blk_i), .cmt_unblk_i(cmt_unblk_i),
    .rob_vld_i(rob_vld_i), .rob_cr_i(rob_cr_i), .rob_empty_i(rob_empty_i),
    .iq_vld_i(iq_vld_i), .iq_cr_i(iq_cr_i),
    .lsq_vld_i(lsq_vld_i), .lsq_cr_i(lsq_cr_i),
    .map_free_i(map_free_i), .renamed_i(renamed_i),
    .disp_i(disp_i), .lsq_disp_i(lsq_disp_i),
    .ser_req_i(ser_req_i), .skid_empty_i(skid_empty_i),
    .state_o(state_o), .block_up_o(block_up_o),
    .reinj_o(reinj_o), .reinj_skid_o(reinj_skid_o), .unblk_err_o(unblk_err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // thread 0 state plus the block-upstream flag that must follow it (R12)
  task automatic chk_st(input string req, input int exp);
    chk(req, "state t0", int'(state_o[2:0]), exp);
    chk("R12", "block_up t0", int'(block_up_o[0]), (exp == 1 || exp == 2) ? 1 : 0);
  endtask

  task automatic quiet;
    flush_i = '0; rob_sq_i = '0; exe_blk_i = '0; exe_unblk_i = '0;
    cmt_blk_i = '0; cmt_unblk_i = '0; rob_vld_i = '0; iq_vld_i = '0;
    lsq_vld_i = '0; ser_req_i = '0;
    renamed_i = '0; disp_i = '0; lsq_disp_i = '0;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic step;
    tick();
    quiet();
  endtask

  task automatic t_reset;
    chk_st("R1", 0);
    chk("R1", "reinj", int'(reinj_o), 0);
    chk("R1", "err", int'(unblk_err_o), 0);
  endtask

  task automatic t_flags;
    exe_blk_i[0] = 1'b1; step(); chk_st("R4", 1);
    chk("R13", "state t1", int'(state_o[5:3]), 0);
    step(); chk_st("R4", 1);
    exe_unblk_i[0] = 1'b1; skid_empty_i[0] = 1'b0; step(); chk_st("R5", 2);
    chk("R5", "err", int'(unblk_err_o[0]), 0);
    step(); chk_st("R5", 2);
    skid_empty_i[0] = 1'b1; step(); chk_st("R5", 0);
    cmt_unblk_i[0] = 1'b1; step();
    chk("R5", "err bad unblock", int'(unblk_err_o[0]), 1);
    chk_st("R5", 0);
    step(); chk("R5", "err one cycle", int'(unblk_err_o[0]), 0);
    cmt_blk_i[0] = 1'b1; cmt_unblk_i[0] = 1'b1; step();
    chk_st("R4", 0);
    chk("R4", "err same-cycle pair", int'(unblk_err_o[0]), 0);
  endtask

  task automatic t_rob_credit;
    rob_vld_i[0] = 1'b1; rob_cr_i[7:0] = 8'd3; rob_empty_i[0] = 1'b1; step(); chk_st("R7", 0);
    renamed_i[7:0] = 8'd2; step(); chk_st("R6", 0);
    step(); chk_st("R6", 0);                 // free = 3 - 2 = 1
    renamed_i[7:0] = 8'd1; step(); chk_st("R6", 0);
    step(); chk_st("R6", 1);                 // free = 3 - 3 = 0
    disp_i[7:0] = 8'd3; step(); chk_st("R6", 2);   // 3 - (3 - 3) = 3
    step(); chk_st("R6", 0);
    rob_vld_i[0] = 1'b1; rob_cr_i[7:0] = 8'd16; step(); chk_st("R7", 0);
  endtask

  task automatic t_lsq_credit;
    lsq_vld_i[0] = 1'b1; lsq_cr_i[7:0] = 8'd2; renamed_i[7:0] = 8'd2; step(); chk_st("R6", 0);
    disp_i[7:0] = 8'd2; step(); chk_st("R6", 1);   // lsq free = 2 - (2 - 0) = 0
    step(); chk_st("R6", 2);
    step(); chk_st("R6", 0);
    lsq_vld_i[0] = 1'b1; lsq_cr_i[7:0] = 8'd8; step();
  endtask

  task automatic t_iq_valid;
    iq_cr_i[7:0] = 8'd0; step(); chk_st("R7", 0);   // credit without valid ignored
    iq_vld_i[0] = 1'b1; iq_cr_i[7:0] = 8'd0; step(); chk_st("R7", 1);
    iq_vld_i[0] = 1'b1; iq_cr_i[7:0] = 8'd16; step(); chk_st("R7", 2);
    step(); chk_st("R7", 0);
  endtask

  task automatic t_map;
    map_free_i[7:0] = 8'd0; step(); chk_st("R8", 1);
    map_free_i[7:0] = 8'd1; step(); chk_st("R8", 2);
    step(); chk_st("R8", 0);
    map_free_i[7:0] = 8'd32;
  endtask

  task automatic t_serial;
    ser_req_i[0] = 1'b1; rob_vld_i[0] = 1'b1; rob_cr_i[7:0] = 8'd16; rob_empty_i[0] = 1'b0;
    step(); chk_st("R10", 4);
    step(); chk_st("R10", 4);
    chk("R11", "no early reinj", int'(reinj_o[0]), 0);
    rob_empty_i[0] = 1'b1; step(); chk_st("R7", 4);   // empty flag needs valid
    rob_vld_i[0] = 1'b1; rob_empty_i[0] = 1'b1; skid_empty_i[0] = 1'b0; step();
    chk_st("R11", 2);
    chk("R11", "reinj", int'(reinj_o[0]), 1);
    chk("R11", "target skid", int'(reinj_skid_o[0]), 1);
    skid_empty_i[0] = 1'b1; step(); chk_st("R11", 0);
    chk("R11", "reinj one cycle", int'(reinj_o[0]), 0);
    ser_req_i[0] = 1'b1; renamed_i[7:0] = 8'd1; step(); chk_st("R10", 4);
    step(); chk_st("R10", 4);
    disp_i[7:0] = 8'd1; step(); chk_st("R10", 4);
    step(); chk_st("R11", 2);
    chk("R11", "reinj normal", int'(reinj_o[0]), 1);
    chk("R11", "target normal", int'(reinj_skid_o[0]), 0);
    step(); chk_st("R11", 0);
  endtask

  task automatic t_squash;
    flush_i[0] = 1'b1; exe_blk_i[0] = 1'b1; step(); chk_st("R2", 3);
    step(); chk_st("R2", 1);
    flush_i[0] = 1'b1; exe_unblk_i[0] = 1'b1; step(); chk_st("R2", 3);
    step(); chk_st("R9", 2);
    step(); chk_st("R9", 0);
    flush_i[0] = 1'b1; step(); chk_st("R2", 3);
    step(); chk_st("R9", 0);
    rob_sq_i[0] = 1'b1; cmt_blk_i[0] = 1'b1; step(); chk_st("R3", 3);
    rob_sq_i[0] = 1'b1; cmt_unblk_i[0] = 1'b1; step(); chk_st("R3", 3);
    step(); chk_st("R9", 0);
    ser_req_i[0] = 1'b1; rob_vld_i[0] = 1'b1; rob_empty_i[0] = 1'b0; step(); chk_st("R10", 4);
    flush_i[0] = 1'b1; step(); chk_st("R2", 3);
    step(); chk_st("R9", 4);
    step(); chk_st("R10", 4);
    rob_vld_i[0] = 1'b1; rob_empty_i[0] = 1'b1; step(); chk_st("R11", 2);
    chk("R11", "reinj after squash", int'(reinj_o[0]), 1);
    step(); chk_st("R9", 0);
    chk("R13", "state t1 final", int'(state_o[5:3]), 0);
  endtask

  initial begin
    quiet();
    rst_n = 1'b0;
    rob_cr_i = {NTHR{8'd16}}; iq_cr_i = {NTHR{8'd16}}; lsq_cr_i = {NTHR{8'd8}};
    rob_empty_i = '1; map_free_i = {NTHR{8'd32}}; skid_empty_i = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    t_reset();
    t_flags();
    t_rob_credit();
    t_lsq_credit();
    t_iq_valid();
    t_map();
    t_serial();
    t_squash();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule